// File: doc/BRIEF.md
# Serial Divider-Ratio Load Port

This block takes a three-wire serial programming stream (bit clock, bit data and a load strobe) and turns it into the divide ratios for the two counters of a frequency synthesizer. One ratio is for the feedback path and holds a 6-bit swallow count A and a 12-bit main count N. The other is a 14-bit reference ratio R. The three serial wires are asynchronous to the system clock. They pass through synchronizers, and edges are found in the system clock domain.

Each frame carries its payload and, as its final bit, a target-select bit. Bits move through an 18-bit payload chain and a one-bit target register. A rising edge on the load wire copies the payload into the holding register picked by the target bit. The other holding register keeps its value. Each holding register gives a one-cycle update strobe when it loads, and a sticky flag that shows it has been loaded at least once since reset.

Top module: `ratio_load_port`

## Requirements
- R1: After reset, `a_out` is 0, `n_out` is 5 and `r_out` is 5. Both update strobes and both loaded flags are low.
- R2: A rising edge of `ser_clk` shifts `ser_data` in. The newest bit enters the target register, and the old target bit moves into payload bit 0. Payload is sent most significant bit first. A feedback frame is 19 bits: N11..N0, then A5..A0, then the target bit.
- R3: A reference frame is 15 bits: R13..R0, then the target bit. R is taken from the low 14 payload bits.
- R4: A target bit of 0 routes a load to the feedback register (`a_out` = payload[5:0], `n_out` = payload[17:6]). A target bit of 1 routes a load to the reference register.
- R5: Shifting bits without a rising edge on `ser_le` leaves all outputs unchanged. A later `ser_le` rising edge loads the bits that were shifted in.
- R6: When a frame is preceded by extra bits, only the last 19 (feedback) or 15 (reference) bits take effect.
- R7: A load into one register leaves the other register's value unchanged.
- R8: Every load gives exactly one single-cycle strobe (`fb_upd` or `ref_upd`). The two strobes are never high together.
- R9: A loaded flag rises in the same cycle as its register's first strobe and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial bit data, asynchronous |
| ser_le | input | 1 | Load strobe, rising edge loads |
| a_out | output | 6 | Held swallow count A |
| n_out | output | 12 | Held main count N |
| r_out | output | 14 | Held reference ratio R |
| fb_upd | output | 1 | One-cycle pulse when A/N load |
| ref_upd | output | 1 | One-cycle pulse when R loads |
| fb_prog | output | 1 | Feedback register loaded since reset |
| ref_prog | output | 1 | Reference register loaded since reset |

## Verification
The assertions assume that each serial wire stays at one level for longer than the synchronizer depth. Then every high and every low phase of `ser_clk` and `ser_le` is seen, and `ser_data` is settled before the bit clock edge reaches the shift stage. The stimulus keeps each wire level for at least four system cycles. It changes data only while the bit clock is low, and it raises the load strobe only after the last bit clock has fallen. Under these conditions a load can never fall on the same cycle as a shift.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef enum logic {
    TGT_FB  = 1'b0,
    TGT_REF = 1'b1
  } tgt_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rl_sync.sv
module rl_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [W-1:0] src;
      if (gi == 0) begin : g_first
        assign src = d;
      end else begin : g_next
        assign src = stg_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[gi] <= '0;
        else        stg_q[gi] <= src;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rl_shift.sv
module rl_shift #(
  parameter int unsigned PAY_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [PAY_W-1:0] payload,
  output logic             tgt_bit
);
  logic [PAY_W-1:0] pay_d, pay_q;
  logic             tgt_d, tgt_q;

  always_comb begin
    pay_d = pay_q;
    tgt_d = tgt_q;
    if (shift_en) begin
      pay_d = {pay_q[PAY_W-2:0], tgt_q};
      tgt_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q <= '0;
      tgt_q <= 1'b0;
    end else begin
      pay_q <= pay_d;
      tgt_q <= tgt_d;
    end
  end

  assign payload = pay_q;
  assign tgt_bit = tgt_q;
endmodule

// File: rtl/rl_word_latch.sv
module rl_word_latch #(
  parameter int unsigned     W       = 14,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] val,
  output logic         stb,
  output logic         prog
);
  logic [W-1:0] val_d, val_q;
  logic         stb_d, stb_q;
  logic         prog_d, prog_q;

  always_comb begin
    val_d  = load ? d : val_q;
    stb_d  = load;
    prog_d = prog_q | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= RST_VAL;
      stb_q  <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      stb_q  <= stb_d;
      prog_q <= prog_d;
    end
  end

  assign val  = val_q;
  assign stb  = stb_q;
  assign prog = prog_q;
endmodule

// File: rtl/ratio_load_port.sv
module ratio_load_port #(
  parameter int unsigned A_W         = 6,
  parameter int unsigned N_W         = 12,
  parameter int unsigned R_W         = 14,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned A_RST       = 0,
  parameter int unsigned N_RST       = 5,
  parameter int unsigned R_RST       = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_le,
  output logic [A_W-1:0] a_out,
  output logic [N_W-1:0] n_out,
  output logic [R_W-1:0] r_out,
  output logic           fb_upd,
  output logic           ref_upd,
  output logic           fb_prog,
  output logic           ref_prog
);
  import rl_pkg::*;

  localparam int unsigned FB_W  = A_W + N_W;
  localparam int unsigned PAY_W = max_u(FB_W, R_W);
  localparam logic [FB_W-1:0] FB_RST = {N_W'(N_RST), A_W'(A_RST)};
  localparam logic [R_W-1:0]  R_RST_V = R_W'(R_RST);

  logic [2:0]       sync_q;
  logic             s_clk, s_data, s_le;
  logic             clk_prev_q, le_prev_q;
  logic             clk_rise, le_rise;
  logic [PAY_W-1:0] payload;
  logic             tgt_bit;
  logic             load_fb, load_ref;
  logic [FB_W-1:0]  fb_val;

  rl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_le, ser_data, ser_clk}),
    .q     (sync_q)
  );
  assign {s_le, s_data, s_clk} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      le_prev_q  <= 1'b0;
    end else begin
      clk_prev_q <= s_clk;
      le_prev_q  <= s_le;
    end
  end

  assign clk_rise = s_clk & ~clk_prev_q;
  assign le_rise  = s_le  & ~le_prev_q;

  rl_shift #(.PAY_W(PAY_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (clk_rise),
    .din      (s_data),
    .payload  (payload),
    .tgt_bit  (tgt_bit)
  );

  // The latch enable is the load edge gated by the target bit
  assign load_fb  = le_rise & (tgt_bit == TGT_FB);
  assign load_ref = le_rise & (tgt_bit == TGT_REF);

  rl_word_latch #(.W(FB_W), .RST_VAL(FB_RST)) u_fb_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_fb),
    .d     (payload[FB_W-1:0]),
    .val   (fb_val),
    .stb   (fb_upd),
    .prog  (fb_prog)
  );

  rl_word_latch #(.W(R_W), .RST_VAL(R_RST_V)) u_ref_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_ref),
    .d     (payload[R_W-1:0]),
    .val   (r_out),
    .stb   (ref_upd),
    .prog  (ref_prog)
  );

  assign a_out = fb_val[A_W-1:0];
  assign n_out = fb_val[FB_W-1:A_W];
endmodule

// File: rtl/ratio_load_port_chk.sv
module ratio_load_port_chk #(
  parameter int unsigned A_W = 6,
  parameter int unsigned N_W = 12,
  parameter int unsigned R_W = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic [A_W-1:0] a_out,
  input logic [N_W-1:0] n_out,
  input logic [R_W-1:0] r_out,
  input logic           fb_upd,
  input logic           ref_upd,
  input logic           fb_prog,
  input logic           ref_prog
);
  p_single_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fb_upd, ref_upd}));
  p_fb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_upd |=> !fb_upd);
  p_ref_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |=> !ref_upd);
  p_fb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_upd |-> $stable({n_out, a_out}));
  p_ref_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_upd |-> $stable(r_out));
  p_fb_prog_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_prog) |-> fb_upd);
  p_ref_prog_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_prog) |-> ref_upd);
  p_fb_prog_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(fb_prog));
  p_ref_prog_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ref_prog));
  p_fb_upd_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_upd |-> fb_prog);
endmodule

bind ratio_load_port ratio_load_port_chk #(.A_W(A_W), .N_W(N_W), .R_W(R_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_out    (a_out),
  .n_out    (n_out),
  .r_out    (r_out),
  .fb_upd   (fb_upd),
  .ref_upd  (ref_upd),
  .fb_prog  (fb_prog),
  .ref_prog (ref_prog)
);

// File: tb/ratio_load_port_tb.sv
module ratio_load_port_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk, rst_n;
  logic        ser_clk, ser_data, ser_le;
  logic [5:0]  a_out;
  logic [11:0] n_out;
  logic [13:0] r_out;
  logic        fb_upd, ref_upd, fb_prog, ref_prog;

  int n_vec, n_bad;
  bit done;
  logic [32:0] exp_q[$];
  logic [17:0] exp_fb;
  logic [13:0] exp_r;

  ratio_load_port u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .a_out(a_out), .n_out(n_out), .r_out(r_out), .fb_upd(fb_upd), .ref_upd(ref_upd),
    .fb_prog(fb_prog), .ref_prog(ref_prog)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  // kind 0 = feedback, 1 = reference; value is the expected word
  task automatic pulse_le(input logic kind, input logic [31:0] val);
    exp_q.push_back({kind, val});
    ser_le = 1'b1;
    repeat (4) @(negedge clk);
    ser_le = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic load_fb(input logic [11:0] n, input logic [5:0] a);
    send_bits({13'd0, n, a, 1'b0}, 19);
    pulse_le(1'b0, {14'd0, n, a});
  endtask

  task automatic load_ref(input logic [13:0] r);
    send_bits({17'd0, r, 1'b1}, 15);
    pulse_le(1'b1, {18'd0, r});
  endtask

  // Monitor: pops an expected item on every strobe
  always @(negedge clk) begin
    if (rst_n && (fb_upd || ref_upd)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected strobe", {30'd0, ref_upd, fb_upd}, 32'd0);
      end else begin
        logic [32:0] it;
        it = exp_q.pop_front();
        chk(fb_upd != ref_upd, "R8 one strobe", {30'd0, ref_upd, fb_upd}, 32'd1);
        if (it[32] == 1'b0) begin
          chk(fb_upd, "R4 feedback target", {31'd0, fb_upd}, 32'd1);
          chk({n_out, a_out} == it[17:0], "R2 feedback word", {14'd0, n_out, a_out}, it[31:0]);
          chk(r_out == exp_r, "R7 reference kept", {18'd0, r_out}, {18'd0, exp_r});
          chk(fb_prog, "R9 fb flag", {31'd0, fb_prog}, 32'd1);
          exp_fb = it[17:0];
        end else begin
          chk(ref_upd, "R4 reference target", {31'd0, ref_upd}, 32'd1);
          chk(r_out == it[13:0], "R3 reference word", {18'd0, r_out}, it[31:0]);
          chk({n_out, a_out} == exp_fb, "R7 feedback kept", {14'd0, n_out, a_out}, {14'd0, exp_fb});
          chk(ref_prog, "R9 ref flag", {31'd0, ref_prog}, 32'd1);
          exp_r = it[13:0];
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_le = 1'b0;
    exp_fb = {12'd5, 6'd0};
    exp_r  = 14'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(a_out == 6'd0, "R1 A reset", {26'd0, a_out}, 32'd0);
    chk(n_out == 12'd5, "R1 N reset", {20'd0, n_out}, 32'd5);
    chk(r_out == 14'd5, "R1 R reset", {18'd0, r_out}, 32'd5);
    chk({fb_prog, ref_prog, fb_upd, ref_upd} == 4'd0, "R1 flags low",
        {28'd0, fb_prog, ref_prog, fb_upd, ref_upd}, 32'd0);

    // R3 reference frame, R9 feedback flag still low
    load_ref(14'd100);
    chk(!fb_prog, "R9 fb flag before load", {31'd0, fb_prog}, 32'd0);

    // R2 feedback frames, including the largest values
    load_fb(12'd300, 6'd7);
    load_fb(12'd4095, 6'd63);

    // R3 boundaries of the reference ratio
    load_ref(14'd16383);
    load_ref(14'd5);

    // R6 extra leading bits are dropped
    send_bits(32'hF, 4);
    load_fb(12'd200, 6'd10);
    send_bits(32'h7, 3);
    load_ref(14'd1234);

    // R5 bits shifted without a load edge change nothing
    send_bits({13'd0, 12'd9, 6'd1, 1'b0}, 19);
    repeat (10) @(negedge clk);
    chk({n_out, a_out} == exp_fb, "R5 fb unchanged without LE", {14'd0, n_out, a_out}, {14'd0, exp_fb});
    chk(r_out == exp_r, "R5 ref unchanged without LE", {18'd0, r_out}, {18'd0, exp_r});
    pulse_le(1'b0, {14'd0, 12'd9, 6'd1});

    // R8 the queue must be drained
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 missing strobe", exp_q.size(), 32'd0);
    chk(fb_prog && ref_prog, "R9 flags stay high", {30'd0, fb_prog, ref_prog}, 32'd3);
    finish_run();
  end
endmodule